// File: doc/BRIEF.md
# Programmable RAM-Based Delay Line

This block delays a stream of data words by a programmable number of clock cycles, using a single-port synchronous RAM as a circular buffer. There is no valid qualifier: a word enters on every cycle and a word leaves on every cycle. One typical use is to push a one-cycle pulse, or a narrow sample, back in time by up to a few thousand clocks.

A self-reloading down-counter produces the RAM address. In every cycle the RAM returns the word already held at that address and writes the incoming word to the same location. The counter's terminal count comes from the sign bit of its decremented value, so no comparator is needed. The delay setting can change at any moment. The counter reads it only when it reloads, so a pass through the buffer that has started always runs to its end.

The data width and the address width are parameters. When `LOW_HALF` is set, the top RAM address bit is held at zero and the upper half of the memory is never touched.

Top module: `prog_delay_line`

## Requirements
- R1: For a setting N between 2 and the maximum, `dout_o` equals the `din_i` word sampled N rising edges earlier. The maximum is DEPTH+1, where DEPTH is 2^ADDR_W.
- R2: In steady state, `tc_o` is high for exactly one cycle in every N-1 cycles. That cycle is the last cycle of each pass.
- R3: The counter samples `dly_i` only in a cycle where `tc_o` is high. A change made at any other time does not shorten or lengthen the pass in progress, and only the value present in the terminal-count cycle sets the length of the next pass.
- R4: After the setting is reduced, outputs up to and including the first cycle after the terminal count keep the old latency. From the second cycle on, every output has the new latency N.
- R5: Settings 0 and 1 behave exactly as setting 2.
- R6: Settings above the maximum behave exactly as the maximum (DEPTH+1 by default).
- R7: While `rst_ni` is low, `dout_o` is 0 and `tc_o` is 1, because the counter is cleared. After release, the first rising edge loads the setting, and `tc_o` is next high after N-1 rising edges in total.
- R8: With `LOW_HALF` set, the maximum delay becomes DEPTH/2+1, larger settings are clamped to it, and the top RAM address bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | DATA_W | Input word, taken on every cycle |
| dly_i | input | DLY_W | Delay setting in cycles, clamped to the legal range |
| dout_o | output | DATA_W | Delayed word |
| tc_o | output | 1 | High in the last cycle of each pass through the buffer |

## Verification
The hardest case to reach is a change of the delay setting partway through a pass. The current pass must run to completion, the latency must switch at a precise cycle, and after an increase the newly used addresses still hold stale words for one pass. The stimulus reaches this case by changing the setting a few cycles into a pass, both downward and upward. It then changes the setting twice within one pass, so that only the value present at the wrap counts. A bench model of the reload schedule predicts every terminal-count cycle and the cycle from which each new latency holds. Both extremes of the range are also run: a period of one cycle at the minimum setting, and a pass over every address at the maximum setting.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int MIN_DLY = 2;

  function automatic int max_delay(int addr_w, bit low_half);
    return (low_half ? (1 << (addr_w - 1)) : (1 << addr_w)) + 1;
  endfunction
endpackage

// File: rtl/dly_clamp.sv
module dly_clamp import dly_pkg::*; #(
  parameter int DLY_W = 13,
  parameter int CNT_W = 13,
  parameter int MAXD  = 4097
) (
  input  logic [DLY_W-1:0] dly_i,
  output logic [CNT_W-1:0] ld_o
);
  int req;

  // reload value is the clamped setting minus two
  always_comb begin
    req = int'(dly_i);
    if (req < MIN_DLY)   req = MIN_DLY;
    else if (req > MAXD) req = MAXD;
    ld_o = CNT_W'(req - MIN_DLY);
  end
endmodule

// File: rtl/dly_ctr.sv
module dly_ctr #(
  parameter int CNT_W = 13,
  parameter int MAXL  = 4095
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ld_i,
  output logic [CNT_W-2:0] addr_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dec;

  assign dec    = cnt_q - CNT_W'(1);
  assign tc_o   = dec[CNT_W-1];  // sign of next value marks the wrap
  assign addr_o = cnt_q[CNT_W-2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= tc_o ? ld_i : dec;
  end

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_o |=> (cnt_q + CNT_W'(1)) == $past(cnt_q));

  p_tc_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt_q == '0);

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> cnt_q == $past(ld_i));

  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAXL));
endmodule

// File: rtl/dly_ram.sv
module dly_ram #(
  parameter int DATA_W = 1,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-before-write: nonblocking read returns the old word
  always_ff @(posedge clk_i) begin
    mem[addr_i] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_o <= '0;
    else         dout_o <= mem[addr_i];
  end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line import dly_pkg::*; #(
  parameter int DATA_W   = 1,
  parameter int ADDR_W   = 12,
  parameter bit LOW_HALF = 1'b0,
  parameter int DLY_W    = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              tc_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int MAXD  = max_delay(ADDR_W, LOW_HALF);
  localparam int MAXL  = MAXD - MIN_DLY;

  logic [CNT_W-1:0]  ld;
  logic [ADDR_W-1:0] cnt_addr;
  logic [ADDR_W-1:0] ram_addr;

  dly_clamp #(.DLY_W(DLY_W), .CNT_W(CNT_W), .MAXD(MAXD)) u_clamp (
    .dly_i (dly_i),
    .ld_o  (ld)
  );

  dly_ctr #(.CNT_W(CNT_W), .MAXL(MAXL)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .addr_o (cnt_addr),
    .tc_o   (tc_o)
  );

  generate
    if (LOW_HALF) begin : g_low
      assign ram_addr = {1'b0, cnt_addr[ADDR_W-2:0]};
      p_low_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_addr[ADDR_W-1]);
    end else begin : g_full
      assign ram_addr = cnt_addr;
    end
  endgenerate

  dly_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (ram_addr),
    .din_i  (din_i),
    .dout_o (dout_o)
  );

  p_rst_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (dout_o == '0) && tc_o);
endmodule

// File: tb/sim_prog_delay_line.sv
module sim_prog_delay_line;
  localparam int DW   = 8;
  localparam int MASK = 8191;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni = 1'b1;
  logic [DW-1:0] din    = '0;
  logic [12:0]   dly0   = 13'd2;
  logic [4:0]    dly1   = 5'd2;
  logic [DW-1:0] q0, q1;
  logic          tc0, tc1;

  prog_delay_line #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .dly_i(dly0),
    .dout_o(q0), .tc_o(tc0));

  prog_delay_line #(.DATA_W(DW), .ADDR_W(4), .LOW_HALF(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .dly_i(dly1),
    .dout_o(q1), .tc_o(tc1));

  int checks = 0, fails = 0, m = 0;
  logic [DW-1:0] hist [8192];
  int n_cur [2], n_new [2], sw [2], next_tc [2], vstart [2];
  int maxd  [2] = '{4097, 9};
  bit act   [2] = '{1'b0, 1'b0};
  bit rel_req = 1'b0, done = 1'b0;
  string lat_tag = "R1", tc_tag = "R2";

  function automatic int clampm(int x, int mx);
    if (x < 2)  return 2;
    if (x > mx) return mx;
    return x;
  endfunction

  task automatic chk(bit ok, string tag, string what, int a, int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at step %0d", tag, what, a, e, m);
    end
  endtask

  task automatic tick();
    int dval [2];
    int qs [2];
    int tcs [2];
    int nn, ev;
    @(negedge clk);
    qs[0] = int'(q0);  qs[1] = int'(q1);
    tcs[0] = int'(tc0); tcs[1] = int'(tc1);
    dval[0] = int'(dly0); dval[1] = int'(dly1);
    for (int i = 0; i < 2; i++) begin
      if (!rst_ni) begin
        chk(qs[i] == 0, "R7", "dout in reset", qs[i], 0);
        chk(tcs[i] == 1, "R7", "tc in reset", tcs[i], 1);
      end else if (act[i]) begin
        if (m >= sw[i]) n_cur[i] = n_new[i];
        if (m >= vstart[i]) begin
          ev = int'(hist[(m - n_cur[i]) & MASK]);
          chk(qs[i] == ev, lat_tag, i == 0 ? "u0 dout" : "u1 dout", qs[i], ev);
        end
        chk(tcs[i] == int'(m == next_tc[i]), tc_tag, i == 0 ? "u0 tc" : "u1 tc",
            tcs[i], int'(m == next_tc[i]));
        if (m == next_tc[i]) begin
          nn = clampm(dval[i], maxd[i]);
          next_tc[i] = m + nn - 1;
          if (nn != n_new[i]) begin
            if (nn > n_new[i] && m + 2 + nn - n_new[i] > vstart[i])
              vstart[i] = m + 2 + nn - n_new[i];
            n_new[i] = nn;
            sw[i] = m + 2;
          end
        end
      end
    end
    if (rel_req) begin
      rst_ni  = 1'b1;
      rel_req = 1'b0;
      for (int i = 0; i < 2; i++) begin
        nn = clampm(dval[i], maxd[i]);
        act[i] = 1'b1;
        n_cur[i] = nn; n_new[i] = nn; sw[i] = m;
        next_tc[i] = m + nn - 1;  // R7: first wrap N-1 edges after release
        vstart[i]  = m + nn + 1;
      end
    end
    din = DW'(m * 29 + (m >> 6));
    hist[m & MASK] = din;
    m++;
  endtask

  task automatic run(int k);
    repeat (k) tick();
  endtask

  task automatic start(int d0, int d1);
    dly0 = 13'(d0);
    dly1 = 5'(d1);
    act[0] = 1'b0; act[1] = 1'b0;
    rst_ni = 1'b0;
    run(3);
    rel_req = 1'b1;
    tick();
  endtask

  task automatic t_min_delay();
    lat_tag = "R1"; tc_tag = "R7";
    start(2, 2);
    run(30);
  endtask

  task automatic t_small();
    lat_tag = "R1"; tc_tag = "R2";
    start(3, 5);
    run(40);
    start(17, 9);  // R8: u1 at its top legal setting
    run(60);
  endtask

  task automatic t_long();
    lat_tag = "R1"; tc_tag = "R2";
    start(3454, 7);
    run(3520);
    start(4097, 3);
    run(4160);
  endtask

  task automatic t_clamp_low();
    lat_tag = "R5"; tc_tag = "R5";
    start(0, 1);
    run(30);
    start(1, 0);
    run(30);
  endtask

  task automatic t_clamp_high();
    lat_tag = "R6"; tc_tag = "R8";
    start(5000, 20);
    run(4160);
  endtask

  task automatic t_shrink();
    lat_tag = "R4"; tc_tag = "R3";
    start(40, 9);
    run(15);
    dly0 = 13'd10; dly1 = 5'd4;
    run(120);
  endtask

  task automatic t_grow();
    lat_tag = "R3"; tc_tag = "R3";
    start(10, 3);
    run(5);
    dly0 = 13'd40; dly1 = 5'd8;
    run(150);
    dly0 = 13'd25; dly1 = 5'd6;
    run(3);
    dly0 = 13'd6; dly1 = 5'd2;
    run(100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", m, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_min_delay();
    t_small();
    t_long();
    t_clamp_low();
    t_clamp_high();
    t_shrink();
    t_grow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule